// File: doc/BRIEF.md
# Synchronous PWM Gate Controller

This block drives the two switches of a synchronous buck power stage. A free-running period counter restarts at the start of every switching cycle, and the high-side command is asserted while the count sits below the duty command. The period and duty values are captured at the start of each cycle. The duty is clamped to a fixed share of the period. The two gate commands pass through a dead-time interlock, so the two switches are never on at once.

Several signals can take over from the duty command, which normally comes from the main control loop:
- An overcurrent comparator flag ends the high-side pulse for the rest of the cycle. The flag is not looked at during a blanking window at the start of each high-side pulse.
- Two window comparator flags report that the output voltage is outside a narrow band around its target. They force either full (clamped) duty or zero duty.
- An over-voltage force input parks the stage with the low side on and the high side off.

Analog sensing, comparators and gate-driver power sit outside the block.

Top module: `pwm_gate_ctrl`

## Requirements
- R1: While `rst` is high, both `hs_gate` and `ls_gate` are low.
- R2: `hs_gate` and `ls_gate` are never high in the same cycle. Every rising edge of either gate is preceded by at least DEAD_CYC consecutive cycles with both gates low.
- R3: Let P be the period and d the effective duty. With steady inputs and no override, each cycle of P clock cycles has `hs_gate` high for d − DEAD_CYC cycles (zero if d ≤ DEAD_CYC) and both gates low for 2·DEAD_CYC cycles (DEAD_CYC if 0 < d ≤ DEAD_CYC). `ls_gate` is high for the remainder. With d = 0, `ls_gate` is high for the whole cycle.
- R4: The effective duty is min(duty, floor(P·MAX_PCT/100)). With the defaults (MAX_PCT = 90) and P = 200, the cap is 180 counts.
- R5: `duty` and `period` are captured in the first cycle of each switching cycle. A change made while a high-side pulse is running does not alter that pulse. It takes effect in the next cycle.
- R6: During the first BLANK_CYC cycles of each high-side pulse, `oc_flag` has no effect.
- R7: When `oc_flag` is high in a high-side cycle after blanking, `hs_gate` goes low at the next clock edge and stays low to the end of that switching cycle, and `ls_gate` follows after the dead time. With the flag held high this gives a pulse of BLANK_CYC + 1 cycles. The next cycle starts normally.
- R8: While `vout_low` is high, the duty command is replaced by the cap from R4.
- R9: While `vout_high` is high, the high side stays off (zero duty). This includes the first clock edge after the flag rises. `vout_high` has priority over `vout_low`.
- R10: While `ovp_force` is high, `hs_gate` is low from the next edge on, and `ls_gate` is high once DEAD_CYC + 1 edges have passed. This holds whatever the values of `en` and the other flags.
- R11: With `en` low and `ovp_force` low, both gates are low from the next edge, and the period counter is held at its first count. Raising `en` resumes normal switching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Switching enable |
| period | input | CNT_W | Switching period in clock cycles |
| duty | input | CNT_W | High-side on-count command |
| oc_flag | input | 1 | High-side overcurrent comparator output |
| vout_low | input | 1 | Output below the lower fast window |
| vout_high | input | 1 | Output above the upper fast window |
| ovp_force | input | 1 | Over-voltage clamp request |
| hs_gate | output | 1 | High-side switch command |
| ls_gate | output | 1 | Low-side switch command |

## Verification
A period counter that drifts or misses its restart shows up as a per-cycle high-side on-time different from d − DEAD_CYC within one switching period. A duty latch that follows its input shows up in the first pulse after a duty change. An overcurrent latch that is left set, or never set, changes the next pulse width. A blanking counter that is off by one moves the tripped pulse length away from BLANK_CYC + 1 on the very first tripped cycle. A dead-time counter fault either merges the two gates or shortens the both-off gap, and it is visible at the first transition after the fault.

// File: rtl/pwm_gate_pkg.sv
package pwm_gate_pkg;

    typedef enum logic [2:0] {
        M_OFF,
        M_CLAMP_LOW,
        M_ZERO,
        M_MAX,
        M_RUN
    } drive_mode_e;

    typedef struct packed {
        logic hs;
        logic ls;
    } gate_pair_t;

    function automatic int unsigned cap_count(int unsigned per, int unsigned pct);
        return (per * pct) / 100;
    endfunction

    // priority: clamp, disable, zero window, max window, normal loop
    function automatic drive_mode_e pick_mode(logic en, logic ovp, logic lo, logic hi);
        if (ovp)      return M_CLAMP_LOW;
        else if (!en) return M_OFF;
        else if (hi)  return M_ZERO;
        else if (lo)  return M_MAX;
        else          return M_RUN;
    endfunction

endpackage

// File: rtl/pwm_period_timer.sv
module pwm_period_timer #(
    parameter int unsigned CNT_W   = 10,
    parameter int unsigned MAX_PCT = 90
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] duty,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] duty_q,
    output logic [CNT_W-1:0] cap_q,
    output logic             cyc_last
);
    import pwm_gate_pkg::*;

    logic [CNT_W-1:0] per_q;
    logic [CNT_W:0]   cnt_inc;
    logic [CNT_W-1:0] cap_v;
    logic [CNT_W-1:0] duty_v;

    always_comb begin
        cnt_inc  = {1'b0, cnt} + 1'b1;
        cyc_last = cnt_inc >= {1'b0, per_q};
        cap_v    = CNT_W'(cap_count(32'(period), MAX_PCT));
        duty_v   = (duty > cap_v) ? cap_v : duty;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            per_q  <= '0;
            duty_q <= '0;
            cap_q  <= '0;
        end else if (!en || cyc_last) begin
            cnt    <= '0;
            per_q  <= period;
            duty_q <= duty_v;
            cap_q  <= cap_v;
        end else begin
            cnt    <= cnt_inc[CNT_W-1:0];
        end
    end

endmodule

// File: rtl/pwm_demand.sv
module pwm_demand #(
    parameter int unsigned CNT_W     = 10,
    parameter int unsigned BLANK_CYC = 75
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic                    ovp_force,
    input  logic                    vout_low,
    input  logic                    vout_high,
    input  logic                    oc_flag,
    input  logic                    hs_gate,
    input  logic [CNT_W-1:0]        cnt,
    input  logic [CNT_W-1:0]        duty_q,
    input  logic [CNT_W-1:0]        cap_q,
    input  logic                    cyc_last,
    output pwm_gate_pkg::gate_pair_t want
);
    import pwm_gate_pkg::*;

    localparam int unsigned BW = $clog2(BLANK_CYC + 2);
    localparam logic [BW-1:0] BLANK_END = BW'(BLANK_CYC);

    drive_mode_e      mode;
    logic [BW-1:0]    blank_cnt;
    logic             blank_done;
    logic             oc_now;
    logic             oc_trip;
    logic [CNT_W-1:0] limit;
    logic             pwm_on;

    always_comb begin
        mode       = pick_mode(en, ovp_force, vout_low, vout_high);
        blank_done = (blank_cnt == BLANK_END);
        oc_now     = hs_gate && blank_done && oc_flag;
        limit      = (mode == M_MAX) ? cap_q : duty_q;
        pwm_on     = (cnt < limit) && !(oc_trip || oc_now);
        want.hs    = ((mode == M_RUN) || (mode == M_MAX)) && pwm_on;
        want.ls    = (mode == M_CLAMP_LOW) ||
                     (((mode == M_RUN) || (mode == M_MAX) || (mode == M_ZERO)) && !want.hs);
    end

    // blanking window: counts high-side cycles from the rising edge
    always_ff @(posedge clk) begin
        if (rst || !hs_gate)
            blank_cnt <= '0;
        else if (!blank_done)
            blank_cnt <= blank_cnt + 1'b1;
    end

    // cycle-by-cycle trip, cleared at each cycle restart
    always_ff @(posedge clk) begin
        if (rst || !en || cyc_last)
            oc_trip <= 1'b0;
        else if (oc_now)
            oc_trip <= 1'b1;
    end

endmodule

// File: rtl/pwm_dead_time.sv
module pwm_dead_time #(
    parameter int unsigned DEAD_CYC = 5
) (
    input  logic                     clk,
    input  logic                     rst,
    input  pwm_gate_pkg::gate_pair_t want,
    output logic                     hs_gate,
    output logic                     ls_gate
);
    localparam int unsigned DW = $clog2(DEAD_CYC + 1);
    localparam logic [DW-1:0] RELOAD = DW'(DEAD_CYC - 1);

    logic [DW-1:0] dcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_gate <= 1'b0;
            ls_gate <= 1'b0;
            dcnt    <= RELOAD;
        end else if (hs_gate && !want.hs) begin
            hs_gate <= 1'b0;
            dcnt    <= RELOAD;
        end else if (ls_gate && !want.ls) begin
            ls_gate <= 1'b0;
            dcnt    <= RELOAD;
        end else if (!hs_gate && !ls_gate) begin
            if (dcnt != '0)
                dcnt <= dcnt - 1'b1;
            else if (want.hs)
                hs_gate <= 1'b1;
            else if (want.ls)
                ls_gate <= 1'b1;
        end
    end

endmodule

// File: rtl/pwm_gate_ctrl.sv
module pwm_gate_ctrl #(
    parameter int unsigned CNT_W     = 10,
    parameter int unsigned MAX_PCT   = 90,
    parameter int unsigned BLANK_CYC = 75,
    parameter int unsigned DEAD_CYC  = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] duty,
    input  logic             oc_flag,
    input  logic             vout_low,
    input  logic             vout_high,
    input  logic             ovp_force,
    output logic             hs_gate,
    output logic             ls_gate
);
    import pwm_gate_pkg::*;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] duty_q;
    logic [CNT_W-1:0] cap_q;
    logic             cyc_last;
    gate_pair_t       want;

    pwm_period_timer #(.CNT_W(CNT_W), .MAX_PCT(MAX_PCT)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .period   (period),
        .duty     (duty),
        .cnt      (cnt),
        .duty_q   (duty_q),
        .cap_q    (cap_q),
        .cyc_last (cyc_last)
    );

    pwm_demand #(.CNT_W(CNT_W), .BLANK_CYC(BLANK_CYC)) u_demand (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .ovp_force (ovp_force),
        .vout_low  (vout_low),
        .vout_high (vout_high),
        .oc_flag   (oc_flag),
        .hs_gate   (hs_gate),
        .cnt       (cnt),
        .duty_q    (duty_q),
        .cap_q     (cap_q),
        .cyc_last  (cyc_last),
        .want      (want)
    );

    pwm_dead_time #(.DEAD_CYC(DEAD_CYC)) u_dead (
        .clk     (clk),
        .rst     (rst),
        .want    (want),
        .hs_gate (hs_gate),
        .ls_gate (ls_gate)
    );

endmodule

// File: rtl/pwm_gate_ctrl_chk.sv
module pwm_gate_ctrl_chk #(
    parameter int unsigned BLANK_CYC = 75,
    parameter int unsigned DEAD_CYC  = 5
) (
    input logic clk,
    input logic rst,
    input logic en,
    input logic oc_flag,
    input logic vout_high,
    input logic ovp_force,
    input logic hs_gate,
    input logic ls_gate
);
    localparam int unsigned SAT = 4096;

    int unsigned off_run;
    int unsigned hs_run;
    int unsigned ovp_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            off_run <= 0;
            hs_run  <= 0;
            ovp_run <= 0;
        end else begin
            if (hs_gate || ls_gate) off_run <= 0;
            else if (off_run < SAT)  off_run <= off_run + 1;
            if (!hs_gate)           hs_run <= 0;
            else if (hs_run < SAT)  hs_run <= hs_run + 1;
            if (!ovp_force)         ovp_run <= 0;
            else if (ovp_run < SAT) ovp_run <= ovp_run + 1;
        end
    end

    a_r1_reset_low: assert property (@(posedge clk) rst |=> (rst || (!hs_gate && !ls_gate)) || $past(!rst));

    a_r2_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(hs_gate && ls_gate));

    a_r2_dead_gap: assert property (@(posedge clk) disable iff (rst)
        ($rose(hs_gate) || $rose(ls_gate)) |-> (off_run >= DEAD_CYC));

    a_r7_trip_after_blank: assert property (@(posedge clk) disable iff (rst)
        (hs_gate && oc_flag && hs_run >= BLANK_CYC) |=> !hs_gate);

    a_r9_high_window_zero: assert property (@(posedge clk) disable iff (rst)
        (en && vout_high && !ovp_force) |=> !hs_gate);

    a_r10_clamp_hs_off: assert property (@(posedge clk) disable iff (rst)
        ovp_force |=> !hs_gate);

    a_r10_clamp_ls_on: assert property (@(posedge clk) disable iff (rst)
        (ovp_run >= DEAD_CYC + 1) |-> ls_gate);

    a_r11_disable_off: assert property (@(posedge clk) disable iff (rst)
        (!en && !ovp_force) |=> (!hs_gate && !ls_gate));

endmodule

bind pwm_gate_ctrl pwm_gate_ctrl_chk #(
    .BLANK_CYC (BLANK_CYC),
    .DEAD_CYC  (DEAD_CYC)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .oc_flag   (oc_flag),
    .vout_high (vout_high),
    .ovp_force (ovp_force),
    .hs_gate   (hs_gate),
    .ls_gate   (ls_gate)
);

// File: tb/pwm_gate_ctrl_bench.sv
module pwm_gate_ctrl_bench;

    localparam int CNT_W = 10;
    localparam int DEAD  = 5;
    localparam int BLANK = 75;
    localparam int P     = 200;

    logic             clk = 1'b0;
    logic             rst;
    logic             en;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] duty;
    logic             oc_flag;
    logic             vout_low;
    logic             vout_high;
    logic             ovp_force;
    logic             hs_gate;
    logic             ls_gate;

    always #2 clk = ~clk;

    pwm_gate_ctrl #(
        .CNT_W(CNT_W), .MAX_PCT(90), .BLANK_CYC(BLANK), .DEAD_CYC(DEAD)
    ) u_pwm_gate_ctrl (
        .clk(clk), .rst(rst), .en(en), .period(period), .duty(duty),
        .oc_flag(oc_flag), .vout_low(vout_low), .vout_high(vout_high),
        .ovp_force(ovp_force), .hs_gate(hs_gate), .ls_gate(ls_gate)
    );

    typedef struct {
        string tag;
        int    mode;   // 0 window of P cycles, 1 current pulse, 2 next pulse
        int    e_hs;
        int    e_ls;
        int    e_off;
    } exp_t;

    exp_t sb_q[$];
    event go;
    event done;
    int   n_chk = 0;
    int   n_err = 0;
    int   overlap_seen = 0;
    int   gap_bad = 0;
    bit   finished = 0;

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // monitor: pops expected items and measures the ports
    initial begin
        forever begin
            exp_t it;
            int   nh;
            int   nl;
            int   no;
            @(go);
            it = sb_q.pop_front();
            nh = 0; nl = 0; no = 0;
            if (it.mode == 0) begin
                for (int i = 0; i < P; i++) begin
                    @(negedge clk);
                    if (hs_gate) nh++;
                    if (ls_gate) nl++;
                    if (!hs_gate && !ls_gate) no++;
                end
                check(it.tag, "hs cycles", nh, it.e_hs);
                check(it.tag, "ls cycles", nl, it.e_ls);
                check(it.tag, "both-off cycles", no, it.e_off);
            end else begin
                if (it.mode == 2) begin
                    while (!hs_gate) @(negedge clk);
                end
                while (hs_gate) begin
                    nh++;
                    @(negedge clk);
                end
                check(it.tag, "pulse width", nh, it.e_hs);
            end
            ->done;
        end
    end

    // continuous interlock watch
    initial begin
        int  off_run = 0;
        bit  ph = 0;
        bit  pl = 0;
        forever begin
            @(negedge clk);
            if (rst) begin
                off_run = 0; ph = 0; pl = 0;
            end else begin
                if (hs_gate && ls_gate) overlap_seen++;
                if ((hs_gate && !ph) || (ls_gate && !pl)) begin
                    if (off_run < DEAD) gap_bad++;
                end
                if (!hs_gate && !ls_gate) off_run++;
                else off_run = 0;
                ph = hs_gate; pl = ls_gate;
            end
        end
    end

    task automatic expect_window(string tag, int h, int l, int o);
        exp_t it;
        it.tag = tag; it.mode = 0; it.e_hs = h; it.e_ls = l; it.e_off = o;
        sb_q.push_back(it);
        ->go;
        @(done);
    endtask

    task automatic expect_pulse(string tag, int mode, int w);
        exp_t it;
        it.tag = tag; it.mode = mode; it.e_hs = w; it.e_ls = 0; it.e_off = 0;
        sb_q.push_back(it);
        ->go;
        @(done);
    endtask

    task automatic settle();
        repeat (3 * P) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual 1 expected 0");
        finish_run();
    end

    initial begin
        rst = 1'b1; en = 1'b0; period = CNT_W'(P); duty = 10'd100;
        oc_flag = 1'b0; vout_low = 1'b0; vout_high = 1'b0; ovp_force = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", "hs in reset", int'(hs_gate), 0);
        check("R1", "ls in reset", int'(ls_gate), 0);
        repeat (2) @(negedge clk);
        rst = 1'b0;

        // R11: disabled after reset
        settle();
        expect_window("R11 disabled", 0, 0, P);

        // R3: nominal duty
        en = 1'b1;
        settle();
        expect_window("R3 duty 100", 95, 95, 10);

        // R3: duty not above dead time
        duty = 10'd3;
        settle();
        expect_window("R3 duty 3", 0, 195, 5);

        // R3: one count above dead time
        duty = 10'd6;
        settle();
        expect_window("R3 duty 6", 1, 189, 10);

        // R3: zero duty
        duty = 10'd0;
        settle();
        expect_window("R3 duty 0", 0, P, 0);

        // R4: command above 90% cap (cap 180)
        duty = 10'd250;
        settle();
        expect_window("R4 cap", 175, 15, 10);

        // R5: duty change during a running pulse
        duty = 10'd100;
        settle();
        while (hs_gate) @(negedge clk);
        while (!hs_gate) @(negedge clk);
        duty = 10'd40;
        expect_pulse("R5 running pulse", 1, 95);
        expect_pulse("R5 next pulse", 2, 35);

        // R6: flag held, pulse shorter than blanking
        duty = 10'd60; oc_flag = 1'b1;
        settle();
        expect_window("R6 blanked", 55, 135, 10);

        // R7: flag held, pulse longer than blanking
        duty = 10'd150;
        settle();
        expect_window("R7 trip", BLANK + 1, P - BLANK - 1 - 10, 10);
        oc_flag = 1'b0;
        settle();
        expect_window("R7 resume", 145, 45, 10);

        // R8: low window forces maximum duty
        duty = 10'd50; vout_low = 1'b1;
        settle();
        expect_window("R8 max duty", 175, 15, 10);

        // R9: high window forces zero, and wins over low window
        vout_high = 1'b1;
        settle();
        expect_window("R9 both windows", 0, P, 0);
        vout_low = 1'b0; duty = 10'd100;
        settle();
        expect_window("R9 zero duty", 0, P, 0);
        vout_high = 1'b0;

        // R10: clamp, also with enable low
        settle();
        ovp_force = 1'b1;
        settle();
        expect_window("R10 clamp", 0, P, 0);
        en = 1'b0;
        settle();
        expect_window("R10 clamp disabled", 0, P, 0);
        ovp_force = 1'b0;

        // R11: disable, then resume
        settle();
        expect_window("R11 off", 0, 0, P);
        en = 1'b1;
        settle();
        expect_window("R11 resume", 95, 95, 10);

        // R2: interlock over the whole run
        check("R2", "overlap cycles", overlap_seen, 0);
        check("R2", "short dead gaps", gap_bad, 0);

        finish_run();
    end

endmodule